// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block is a supervisory timer. It holds a 7-bit down-counter that steps once per prescaled tick. Software must refresh the counter before bit 6 clears. The refresh is also refused while the counter still sits above a programmed window value. A refresh that comes too early, an expiry that comes too late, or a refresh value already below 0x40 each raise a one-cycle reset request. This happens only once the watchdog has been armed.

An early-warning flag is set when the counter steps down onto 0x40, which is the last value before expiry. This flag can drive an interrupt line. Software reaches three word registers through a synchronous single-cycle write port and a combinational read port:
- Control at 0x0: counter in bits 6:0, arm bit 7.
- Configuration at 0x4: window in bits 6:0, prescale exponent in bits 10:8, interrupt enable in bit 12.
- Status at 0x8: early-warning flag in bit 0.

The prescaled tick fires once every `BASE_DIV << exponent` clock cycles.

Top module: `wdog_window`

## Requirements
- R1: After reset the control register reads 0x7F (counter 0x7F, not armed), configuration reads 0x7F (window 0x7F, exponent 0, interrupt enable 0), status reads 0, and both `rst_req` and `irq` are low.
- R2: The counter steps down by one every `BASE_DIV << exponent` cycles, wrapping from 0x00 to 0x7F, whether armed or not. A control write loads the counter in place of that cycle's step.
- R3: The arm bit (control bit 7) is set by writing 1 and stays set; writing 0 to it has no effect until reset.
- R4: When armed, a step of the counter from 0x40 to 0x3F makes `rst_req` high in the cycle after that clock edge, for exactly one cycle.
- R5: A control write with a counter value below 0x40 raises `rst_req` for one cycle after the write. This applies if the block is already armed or if the same write sets the arm bit.
- R6: When already armed, a control write made while the current counter is above the window raises `rst_req`. A write with the counter equal to or below the window does not.
- R7: While not armed, `rst_req` never rises from expiry or from an early refresh.
- R8: Status bit 0 is set when the counter steps down onto 0x40, whether or not the interrupt is enabled.
- R9: Writing 0 to status bit 0 clears the flag; writing 1 leaves it unchanged.
- R10: Configuration bit 12 is set-only until reset, and `irq` is high exactly when both it and the status flag are set.
- R11: The window field (configuration bits 6:0) and exponent field (bits 10:8) read back any value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request |
| irq | output | 1 | Early-warning interrupt |

## Verification
The one-cycle check on `rst_req` assumes software never issues two offending events on adjacent cycles. The stimulus always idles several cycles between control writes. The window checks take for granted that the counter can only fall between the sampling of its value and the write edge. The bench therefore computes each expected early-refresh outcome from the counter value read during the write cycle itself. Timing sweeps run with a small `BASE_DIV` so that all eight exponents fit in a short run.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    localparam int CNT_W = 7;
    localparam int PSC_W = 3;

    localparam logic [CNT_W-1:0] CNT_INIT  = 7'h7F;
    localparam logic [CNT_W-1:0] CNT_FLOOR = 7'h40;

    localparam int OFS_CTRL = 0;
    localparam int OFS_CFG  = 4;
    localparam int OFS_STAT = 8;

    localparam int EN_BIT   = 7;
    localparam int PSC_LSB  = 8;
    localparam int IE_BIT   = 12;
    localparam int FLAG_BIT = 0;

    typedef struct packed {
        logic             ie;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] win;
    } cfg_t;

    typedef struct packed {
        logic late;
        logic low;
        logic early;
    } trip_t;

    function automatic logic any_trip(trip_t t);
        return t.late | t.low | t.early;
    endfunction

endpackage

// File: rtl/wdw_tick_gen.sv
module wdw_tick_gen
    import wdw_pkg::*;
#(
    parameter int BASE_DIV = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int DW = $clog2(BASE_DIV) + (1 << PSC_W);

    logic [DW-1:0] div_q;
    logic [DW-1:0] limit;

    // period = BASE_DIV << psc cycles
    assign limit = (DW'(BASE_DIV) << psc) - DW'(1);
    assign tick  = (div_q >= limit);

    always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/wdw_cfg_regs.sv
module wdw_cfg_regs
    import wdw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_wr,
    input  logic stat_wr,
    input  cfg_t cfg_wdata,
    input  logic flag_wdata,
    input  logic hit_floor,
    output cfg_t cfg_q,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.ie  <= 1'b0;
            cfg_q.psc <= '0;
            cfg_q.win <= CNT_INIT;
        end else if (cfg_wr) begin
            cfg_q.ie  <= cfg_q.ie | cfg_wdata.ie;
            cfg_q.psc <= cfg_wdata.psc;
            cfg_q.win <= cfg_wdata.win;
        end
    end

    // hardware set wins over a same-cycle software clear
    always_ff @(posedge clk) begin
        if (rst)                          flag_q <= 1'b0;
        else if (hit_floor)               flag_q <= 1'b1;
        else if (stat_wr && !flag_wdata)  flag_q <= 1'b0;
    end
endmodule

// File: rtl/wdw_down_core.sv
module wdw_down_core
    import wdw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             en_wdata,
    input  logic [CNT_W-1:0] win,
    output logic [CNT_W-1:0] cnt_q,
    output logic             en_q,
    output logic             hit_floor,
    output logic             rst_req
);
    trip_t trip;
    logic  en_nxt;

    always_comb begin
        en_nxt     = en_q | (ctrl_wr & en_wdata);
        trip.late  = en_q & tick & ~ctrl_wr & (cnt_q == CNT_FLOOR);
        trip.low   = ctrl_wr & en_nxt & (cnt_wdata < CNT_FLOOR);
        trip.early = ctrl_wr & en_q & (cnt_q > win);
    end

    assign hit_floor = tick & ~ctrl_wr & (cnt_q == CNT_FLOOR + 7'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= CNT_INIT;
            en_q    <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            en_q    <= en_nxt;
            rst_req <= any_trip(trip);
            if (ctrl_wr)   cnt_q <= cnt_wdata;
            else if (tick) cnt_q <= cnt_q - 7'd1;
        end
    end
endmodule

// File: rtl/wdog_window.sv
module wdog_window
    import wdw_pkg::*;
#(
    parameter int BASE_DIV = 4096,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic              irq
);
    logic             ctrl_wr, cfg_wr, stat_wr;
    logic             tick, en_q, flag_q, hit_floor, ie_q;
    logic [CNT_W-1:0] cnt_q;
    cfg_t             cfg_q, cfg_wdata;
    logic             unused_wdata;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign cfg_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
    assign stat_wr = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));

    assign cfg_wdata.ie  = bus_wdata[IE_BIT];
    assign cfg_wdata.psc = bus_wdata[PSC_LSB +: PSC_W];
    assign cfg_wdata.win = bus_wdata[CNT_W-1:0];
    assign unused_wdata  = ^{bus_wdata[DATA_W-1:IE_BIT+1], bus_wdata[PSC_LSB+PSC_W]};

    wdw_tick_gen #(.BASE_DIV(BASE_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .psc  (cfg_q.psc),
        .tick (tick)
    );

    wdw_down_core u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .ctrl_wr   (ctrl_wr),
        .cnt_wdata (bus_wdata[CNT_W-1:0]),
        .en_wdata  (bus_wdata[EN_BIT]),
        .win       (cfg_q.win),
        .cnt_q     (cnt_q),
        .en_q      (en_q),
        .hit_floor (hit_floor),
        .rst_req   (rst_req)
    );

    wdw_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .stat_wr    (stat_wr),
        .cfg_wdata  (cfg_wdata),
        .flag_wdata (bus_wdata[FLAG_BIT]),
        .hit_floor  (hit_floor),
        .cfg_q      (cfg_q),
        .flag_q     (flag_q)
    );

    assign ie_q = cfg_q.ie;
    assign irq  = flag_q & ie_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            bus_rdata[CNT_W-1:0] = cnt_q;
            bus_rdata[EN_BIT]    = en_q;
        end else if (bus_addr == ADDR_W'(OFS_CFG)) begin
            bus_rdata[CNT_W-1:0]        = cfg_q.win;
            bus_rdata[PSC_LSB +: PSC_W] = cfg_q.psc;
            bus_rdata[IE_BIT]           = cfg_q.ie;
        end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
            bus_rdata[FLAG_BIT] = flag_q;
        end
    end
endmodule

// File: rtl/wdw_checker.sv
module wdw_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic [3:0] bus_addr,
    input logic       arm_wdata,
    input logic       rst_req,
    input logic       irq,
    input logic [6:0] cnt,
    input logic       en,
    input logic       flag,
    input logic       ie,
    input logic       tick
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == 4'h0);

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctrl_wr) |=> (cnt == 7'($past(cnt) - 7'd1)));

    assert_arm_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        en |=> en);

    assert_late_trip_R4: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !ctrl_wr && cnt == 7'h40) |=> rst_req);

    assert_quiet_unarmed_R7: assert property (@(posedge clk) disable iff (rst)
        (!en && !(ctrl_wr && arm_wdata)) |=> !rst_req);

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctrl_wr && cnt == 7'h41) |=> flag);

    assert_ie_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        ie |=> ie);

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag && ie));
endmodule

bind wdog_window wdw_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr[3:0]),
    .arm_wdata (bus_wdata[7]),
    .rst_req   (rst_req),
    .irq       (irq),
    .cnt       (cnt_q),
    .en        (en_q),
    .flag      (flag_q),
    .ie        (ie_q),
    .tick      (tick)
);

// File: tb/wdog_window_tb.sv
module wdog_window_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BDIV       = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req, irq;

    int n_chk = 0;
    int n_fail = 0;
    int wide = 0;
    logic rr_prev = 1'b0;
    logic [6:0] cur;
    logic last_rr;

    wdog_window #(.BASE_DIV(BDIV), .ADDR_W(4), .DATA_W(32)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst_req && rr_prev) wide++;
        rr_prev <= rst_req;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1 cur = bus_rdata[6:0];
        @(negedge clk);
        bus_wr = 1'b0;
        last_rr = rst_req;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        logic [6:0]  prev;
        logic        found;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'h0, v); check("R1 ctrl", v, 32'h7F);
        check("R1 rst_req", {31'd0, rst_req}, 0);
        check("R1 irq", {31'd0, irq}, 0);
        rd(4'h4, v); check("R1 cfg", v, 32'h7F);
        rd(4'h8, v); check("R1 stat", v, 0);

        // R11 window/exponent readback sweep
        for (int w = 0; w < 128; w++) begin
            wr(4'h4, 32'(w) | (32'(w % 8) << 8));
            rd(4'h4, v);
            check("R11 cfg readback", v, 32'(w) | (32'(w % 8) << 8));
        end

        // R2 tick period for every exponent
        for (int p = 0; p < 8; p++) begin
            int t, nchg, ta;
            wr(4'h4, 32'h7F | (32'(p) << 8));
            wr(4'h0, 32'h7F);
            rd(4'h0, v); prev = v[6:0];
            t = 0; nchg = 0; ta = 0;
            while (nchg < 3 && t < 5000) begin
                rd(4'h0, v); t++;
                if (v[6:0] != prev) begin
                    nchg++;
                    if (nchg == 2) ta = t;
                    if (nchg == 3) begin
                        check("R2 period", 32'(t - ta), 32'(BDIV << p));
                        check("R2 step", {25'd0, v[6:0]}, {25'd0, 7'(prev - 7'd1)});
                    end
                    prev = v[6:0];
                end
            end
        end

        // R2 wrap from 0x00 to 0x7F
        wr(4'h4, 32'h7F);
        wr(4'h0, 32'h02);
        found = 1'b0;
        for (int i = 0; i < 100 && !found; i++) begin
            rd(4'h0, v);
            if (v[6:0] == 7'h00) found = 1'b1;
        end
        repeat (BDIV) rd(4'h0, v);
        check("R2 wrap", {25'd0, v[6:0]}, 32'h7F);

        // R7 / R8 unarmed expiry: flag set, no request, no irq
        wr(4'h8, 0);
        wr(4'h0, 32'h41);
        found = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rst_req) found = 1'b1;
        end
        check("R7 no request while unarmed", {31'd0, found}, 0);
        rd(4'h8, v); check("R8 flag set without ie", v, 1);
        check("R10 irq low without ie", {31'd0, irq}, 0);

        // R9 flag clear semantics
        wr(4'h8, 1); rd(4'h8, v); check("R9 write 1 ignored", v, 1);
        wr(4'h8, 0); rd(4'h8, v); check("R9 write 0 clears", v, 0);

        // R3 arming, set-only
        wr(4'h4, 32'h7F | (32'd7 << 8));
        wr(4'h0, 32'hFF);
        check("R5 arming write no trip", {31'd0, last_rr}, 0);
        rd(4'h0, v); check("R3 armed", {31'd0, v[7]}, 1);
        wr(4'h0, 32'h7F);
        check("R6 refresh in window", {31'd0, last_rr}, 0);
        rd(4'h0, v); check("R3 arm sticky", {31'd0, v[7]}, 1);

        // R6 early refresh
        wr(4'h0, 32'h60);
        check("R6 refresh below 7F", {31'd0, last_rr}, {31'd0, cur > 7'h7F});
        wr(4'h4, 32'h55 | (32'd7 << 8));
        wr(4'h0, 32'h70);
        check("R6 early refresh trips", {31'd0, last_rr}, {31'd0, cur > 7'h55});
        check("R6 early precondition", {31'd0, cur > 7'h55}, 1);

        // R6 boundary: counter equal to window
        wr(4'h4, 32'h7F | (32'd7 << 8));
        wr(4'h0, 32'h55);
        wr(4'h4, 32'h55 | (32'd7 << 8));
        wr(4'h0, 32'h70);
        check("R6 boundary accepted", {31'd0, last_rr}, {31'd0, cur > 7'h55});
        check("R6 boundary precondition", {31'd0, cur > 7'h55}, 0);

        // R5 low-value write
        wr(4'h4, 32'h7F | (32'd7 << 8));
        wr(4'h0, 32'h30);
        check("R5 low write trips", {31'd0, last_rr}, 1);
        wr(4'h0, 32'h7F);
        check("R5 valid refresh no trip", {31'd0, last_rr}, 0);

        // R4 late expiry
        wr(4'h4, 32'h7F);
        wr(4'h8, 0);
        wr(4'h0, 32'h42);
        found = 1'b0;
        for (int i = 0; i < 100 && !found; i++) begin
            rd(4'h0, v);
            if (v[6:0] == 7'h3F) begin
                found = 1'b1;
                check("R4 request on expiry", {31'd0, rst_req}, 1);
                @(negedge clk);
                check("R4 one cycle wide", {31'd0, rst_req}, 0);
            end
        end
        check("R4 expiry reached", {31'd0, found}, 1);
        rd(4'h8, v); check("R8 flag before expiry", v, 1);

        // R10 interrupt enable
        wr(4'h4, 32'h7F | (32'd1 << 12));
        check("R10 irq raised", {31'd0, irq}, 1);
        wr(4'h4, 32'h7F);
        rd(4'h4, v); check("R10 ie sticky", {31'd0, v[12]}, 1);
        check("R10 irq held", {31'd0, irq}, 1);
        wr(4'h8, 0);
        check("R10 irq follows flag", {31'd0, irq}, 0);

        check("R4 no wide pulse", 32'(wide), 0);
        summary();
    end
endmodule